// File: doc/BRIEF.md
# Hamming ECC Syndrome Corrector

This block takes the three check bytes that were stored next to a flash data chunk and the three check bytes recomputed over the same chunk when it was read back. It classifies the result into one of four outcomes. When exactly one data bit is wrong, it also gives the location of that bit: a 9-bit byte offset within the chunk and a 3-bit bit index within that byte. A separate read-modify-write stage uses that location to invert the bit in the data buffer.

A caller presents both check words and pulses a start strobe for one cycle. One clock later the block raises a done strobe for one cycle and registers a status code together with the location. The status code is one of: clean, data bit corrected, error confined to the check bytes, or uncorrectable. Stored check bytes that are all ones mark a page that was erased and never programmed. When an enable input is set, such a page is treated as clean.

Top module: `hsc_corrector`

## Requirements
- R1: The syndrome is the bitwise XOR of the stored and computed 24-bit check words, where byte k sits at bits [8k+7:8k]. A zero syndrome gives status 0 (clean).
- R2: When the ignore-erased enable is 1 and every stored check bit is 1, the status is 0 (clean), whatever the syndrome is. When the enable is 0, the normal classification applies.
- R3: The syndrome is correctable when, in every syndrome byte, each bit pair (2i+1, 2i) holds two different values. A correctable syndrome gives status 1 (data corrected) and bit index {d2[7], d2[5], d2[3]}.
- R4: For a correctable syndrome, the byte offset from MSB to LSB is {d2[1], d1[7], d1[5], d1[3], d1[1], d0[7], d0[5], d0[3], d0[1]}.
- R5: A syndrome that is not correctable and has exactly one bit set gives status 2 (error in the check bytes only).
- R6: Any other nonzero syndrome gives status 3 (uncorrectable).
- R7: The status and location register on the clock edge where start is sampled high. done is high for exactly the following cycle. Without start, the outputs hold their values.
- R8: The byte offset and bit index are zero whenever the status is not 1.
- R9: After reset, done, status, byte offset and bit index are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Evaluate the present check words |
| ignore_erased_i | input | 1 | Treat an all-ones stored check word as clean |
| stored_ecc_i | input | 24 | Check bytes read from flash |
| calc_ecc_i | input | 24 | Check bytes recomputed over the data |
| done_o | output | 1 | One-cycle result strobe |
| status_o | output | 2 | 0 clean, 1 data corrected, 2 check-byte error, 3 uncorrectable |
| byte_idx_o | output | 9 | Byte offset of the bad bit |
| bit_idx_o | output | 3 | Bit index within that byte |

## Verification
The bench builds the block with its default of three syndrome bytes, which gives a 9-bit byte offset. This size covers the full 512-byte address range, so both extremes are reached: offset 0 with bit 0, and offset 511 with bit 7. Correctable syndromes in the bench are assembled from a chosen location. Single-bit syndromes are taken at the lowest and highest bit positions. The erased check is run both with the enable set and with it clear, including a case where an all-ones stored word would otherwise be correctable.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
    localparam int unsigned HSC_BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_CLEAN    = 2'd0,
        ST_FIX_DATA = 2'd1,
        ST_FIX_ECC  = 2'd2,
        ST_FATAL    = 2'd3
    } hsc_status_e;
endpackage

// File: rtl/hsc_pair_test.sv
module hsc_pair_test
    import hsc_pkg::*;
(
    input  logic [HSC_BYTE_W-1:0] syn_byte_i,
    output logic                  split_o
);
    localparam int unsigned PAIRS = HSC_BYTE_W / 2;

    logic [PAIRS-1:0] pair_diff;

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        assign pair_diff[p] = syn_byte_i[2*p+1] ^ syn_byte_i[2*p];
    end

    assign split_o = &pair_diff;
endmodule

// File: rtl/hsc_pos_extract.sv
module hsc_pos_extract
    import hsc_pkg::*;
#(
    parameter int unsigned SYN_BYTES = 3,
    localparam int unsigned SYN_W  = SYN_BYTES * HSC_BYTE_W,
    localparam int unsigned ADDR_W = 4 * (SYN_BYTES - 1) + 1
) (
    input  logic [SYN_W-1:0]  syn_i,
    output logic [ADDR_W-1:0] byte_pos_o,
    output logic [2:0]        bit_pos_o
);
    localparam int unsigned TOP = HSC_BYTE_W * (SYN_BYTES - 1);

    for (genvar b = 0; b < SYN_BYTES - 1; b++) begin : g_low
        for (genvar j = 0; j < 4; j++) begin : g_odd
            assign byte_pos_o[4*b+j] = syn_i[HSC_BYTE_W*b + 2*j + 1];
        end
    end

    assign byte_pos_o[ADDR_W-1] = syn_i[TOP+1];

    for (genvar j = 0; j < 3; j++) begin : g_bit
        assign bit_pos_o[j] = syn_i[TOP + 2*j + 3];
    end
endmodule

// File: rtl/hsc_single_bit.sv
module hsc_single_bit #(
    parameter int unsigned W = 24
) (
    input  logic [W-1:0] vec_i,
    output logic         one_o
);
    assign one_o = (vec_i != '0) && ((vec_i & (vec_i - W'(1))) == '0);
endmodule

// File: rtl/hsc_corrector.sv
module hsc_corrector
    import hsc_pkg::*;
#(
    parameter int unsigned SYN_BYTES = 3,
    localparam int unsigned SYN_W  = SYN_BYTES * HSC_BYTE_W,
    localparam int unsigned ADDR_W = 4 * (SYN_BYTES - 1) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              ignore_erased_i,
    input  logic [SYN_W-1:0]  stored_ecc_i,
    input  logic [SYN_W-1:0]  calc_ecc_i,
    output logic              done_o,
    output logic [1:0]        status_o,
    output logic [ADDR_W-1:0] byte_idx_o,
    output logic [2:0]        bit_idx_o
);
    typedef struct packed {
        logic              done;
        hsc_status_e       status;
        logic [ADDR_W-1:0] byte_idx;
        logic [2:0]        bit_idx;
    } hsc_state_t;

    hsc_state_t state_d, state_q;

    logic [SYN_W-1:0]     syn;
    logic [SYN_BYTES-1:0] byte_split;
    logic                 all_split;
    logic                 one_bit;
    logic                 erased;
    logic [ADDR_W-1:0]    pos_byte;
    logic [2:0]           pos_bit;

    assign syn    = stored_ecc_i ^ calc_ecc_i;
    assign erased = ignore_erased_i && (&stored_ecc_i);

    for (genvar k = 0; k < SYN_BYTES; k++) begin : g_split
        hsc_pair_test i_pair (
            .syn_byte_i (syn[HSC_BYTE_W*k +: HSC_BYTE_W]),
            .split_o    (byte_split[k])
        );
    end
    assign all_split = &byte_split;

    hsc_single_bit #(.W(SYN_W)) i_one (
        .vec_i (syn),
        .one_o (one_bit)
    );

    hsc_pos_extract #(.SYN_BYTES(SYN_BYTES)) i_pos (
        .syn_i      (syn),
        .byte_pos_o (pos_byte),
        .bit_pos_o  (pos_bit)
    );

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        if (start_i) begin
            state_d.done     = 1'b1;
            state_d.byte_idx = '0;
            state_d.bit_idx  = '0;
            if (syn == '0) begin
                state_d.status = ST_CLEAN;
            end else if (erased) begin
                state_d.status = ST_CLEAN;
            end else if (all_split) begin
                state_d.status   = ST_FIX_DATA;
                state_d.byte_idx = pos_byte;
                state_d.bit_idx  = pos_bit;
            end else if (one_bit) begin
                state_d.status = ST_FIX_ECC;
            end else begin
                state_d.status = ST_FATAL;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{done: 1'b0, status: ST_CLEAN, byte_idx: '0, bit_idx: '0};
        end else begin
            state_q <= state_d;
        end
    end

    assign done_o     = state_q.done;
    assign status_o   = state_q.status;
    assign byte_idx_o = state_q.byte_idx;
    assign bit_idx_o  = state_q.bit_idx;
endmodule

// File: rtl/hsc_checker.sv
module hsc_checker #(
    parameter int unsigned SYN_W  = 24,
    parameter int unsigned ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              ignore_erased_i,
    input logic [SYN_W-1:0]  stored_ecc_i,
    input logic [SYN_W-1:0]  calc_ecc_i,
    input logic              done_o,
    input logic [1:0]        status_o,
    input logic [ADDR_W-1:0] byte_idx_o,
    input logic [2:0]        bit_idx_o
);
    p_done_follows_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ($stable(status_o) && $stable(byte_idx_o) && $stable(bit_idx_o)));

    p_zero_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && stored_ecc_i == calc_ecc_i) |=> status_o == 2'd0);

    p_erased_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && ignore_erased_i && (&stored_ecc_i)) |=> status_o == 2'd0);

    p_single_ecc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !(ignore_erased_i && (&stored_ecc_i))
         && $countones(stored_ecc_i ^ calc_ecc_i) == 1) |=> status_o == 2'd2);

    p_idx_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        status_o != 2'd1 |-> (byte_idx_o == '0 && bit_idx_o == '0));
endmodule

bind hsc_corrector hsc_checker #(.SYN_W(SYN_W), .ADDR_W(ADDR_W)) i_hsc_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (start_i),
    .ignore_erased_i (ignore_erased_i),
    .stored_ecc_i    (stored_ecc_i),
    .calc_ecc_i      (calc_ecc_i),
    .done_o          (done_o),
    .status_o        (status_o),
    .byte_idx_o      (byte_idx_o),
    .bit_idx_o       (bit_idx_o)
);

// File: tb/test_hsc_corrector.sv
`timescale 1ns/1ps
module test_hsc_corrector;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        ign = 1'b0;
    logic [23:0] stored = '0;
    logic [23:0] calc = '0;
    logic        done;
    logic [1:0]  status;
    logic [8:0]  byte_idx;
    logic [2:0]  bit_idx;

    int n_checks = 0;
    int n_errs   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    hsc_corrector i_hsc_corrector (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start),
        .ignore_erased_i (ign),
        .stored_ecc_i    (stored),
        .calc_ecc_i      (calc),
        .done_o          (done),
        .status_o        (status),
        .byte_idx_o      (byte_idx),
        .bit_idx_o       (bit_idx)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // correctable syndrome built from a chosen location: odd bit carries value, even bit its inverse
    function automatic logic [23:0] make_syn(input logic [8:0] b, input logic [2:0] k);
        logic [23:0] s;
        logic [11:0] odd;
        odd = {k[2], k[1], k[0], b[8], b[7], b[6], b[5], b[4], b[3], b[2], b[1], b[0]};
        // odd[j] -> syndrome bit 2*((j/4)*4 + j%4)+1 ordering: d0 pairs 0..3, d1 pairs 0..3, d2 pairs 0..3
        s = '0;
        s[1]  = odd[0];  s[3]  = odd[1];  s[5]  = odd[2];  s[7]  = odd[3];
        s[9]  = odd[4];  s[11] = odd[5];  s[13] = odd[6];  s[15] = odd[7];
        s[17] = odd[8];  s[19] = odd[9];  s[21] = odd[10]; s[23] = odd[11];
        for (int p = 0; p < 12; p++) s[2*p] = ~s[2*p+1];
        return s;
    endfunction

    task automatic fire(input logic [23:0] st, input logic [23:0] ca, input logic ig);
        @(negedge clk);
        start = 1'b1; stored = st; calc = ca; ign = ig;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic t_reset();
        chk("R9 done", 32'(done), 0);
        chk("R9 status", 32'(status), 0);
        chk("R9 byte", 32'(byte_idx), 0);
        chk("R9 bit", 32'(bit_idx), 0);
    endtask

    task automatic t_clean();
        fire(24'h3C5A96, 24'h3C5A96, 1'b0);
        chk("R7 done after start", 32'(done), 1);
        chk("R1 zero syndrome", 32'(status), 0);
        @(negedge clk);
        chk("R7 done one cycle", 32'(done), 0);
    endtask

    task automatic t_correct(input logic [8:0] b, input logic [2:0] k, input logic [23:0] base);
        fire(base ^ make_syn(b, k), base, 1'b0);
        chk("R3 status", 32'(status), 1);
        chk("R3 bit index", 32'(bit_idx), 32'(k));
        chk("R4 byte index", 32'(byte_idx), 32'(b));
    endtask

    task automatic t_ecc_single(input int pos);
        fire(24'h123456 ^ (24'h1 << pos), 24'h123456, 1'b0);
        chk("R5 status", 32'(status), 2);
        chk("R8 byte zero", 32'(byte_idx), 0);
        chk("R8 bit zero", 32'(bit_idx), 0);
    endtask

    task automatic t_fatal();
        fire(24'h000003, 24'h000000, 1'b0);
        chk("R6 two bits", 32'(status), 3);
        chk("R8 byte zero fatal", 32'(byte_idx), 0);
        fire(24'h55F055, 24'h000000, 1'b0);
        chk("R6 one byte unsplit", 32'(status), 3);
    endtask

    task automatic t_erased();
        fire(24'hFFFFFF, 24'hFFFFFE, 1'b1);
        chk("R2 erased ignored", 32'(status), 0);
        fire(24'hFFFFFF, 24'hFFFFFE, 1'b0);
        chk("R2 enable clear", 32'(status), 2);
        fire(24'hFFFFFF, 24'hFFFFFF ^ make_syn(9'd77, 3'd2), 1'b1);
        chk("R2 erased over correctable", 32'(status), 0);
        chk("R8 erased byte zero", 32'(byte_idx), 0);
        fire(24'hFFFFFF, 24'hFFFFFF ^ make_syn(9'd77, 3'd2), 1'b0);
        chk("R2 correctable when clear", 32'(status), 1);
        chk("R4 byte 77", 32'(byte_idx), 77);
    endtask

    task automatic t_hold();
        fire(24'h0 ^ make_syn(9'd300, 3'd5), 24'h0, 1'b0);
        chk("R3 pre-hold", 32'(status), 1);
        @(negedge clk);
        stored = 24'h000003; calc = 24'h0;
        repeat (3) @(negedge clk);
        chk("R7 hold status", 32'(status), 1);
        chk("R7 hold byte", 32'(byte_idx), 300);
        chk("R7 hold bit", 32'(bit_idx), 5);
        chk("R7 no done", 32'(done), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_errs++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end

    initial begin
        #1;
        t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean();
        t_correct(9'd0, 3'd0, 24'h000000);
        t_correct(9'd511, 3'd7, 24'h9ABCDE);
        t_correct(9'd258, 3'd3, 24'h0F0F0F);
        t_correct(9'd165, 3'd6, 24'hA1B2C3);
        t_ecc_single(0);
        t_ecc_single(23);
        t_ecc_single(12);
        t_fatal();
        t_erased();
        t_hold();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end
endmodule